// File: doc/BRIEF.md
# Lane-Aware Vector Element Broadcaster

This unit takes a 256-bit vector operand and returns a 256-bit vector in which one chosen element has been copied into every element slot. The vector is treated as two independent 128-bit halves. In the two per-half modes, the same element index is applied to each half separately, so each half of the result carries a copy of that half's own element. The index comes either from a 64-bit scalar operand or from a short immediate. A third mode ignores the halves and copies the least significant element of the whole vector across all 256 bits. Element widths are 8, 16, 32 and 64 bits in every mode, and also 128 bits in the whole-vector mode.

Operations enter through a valid/ready port and leave through a valid/ready port after one register stage. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result appears on the next cycle with `out_valid` high. The result stays on the outputs, unchanged, until a rising edge where `out_ready` is high. While a result is waiting and `out_ready` is low, `in_ready` is low. When `out_ready` is high, a new operation can be accepted on the same edge that the waiting result leaves. The data inputs are only sampled on an accepting edge.

Top module: `vec_bcast_unit`

## Requirements
- R1: In scalar-indexed mode (`in_mode`=0), the index is `in_scalar` modulo the number of elements in a 128-bit half: 16, 8, 4 or 2 for size codes 0, 1, 2 and 3 (8, 16, 32 and 64 bits). All higher scalar bits are ignored.
- R2: In scalar-indexed mode, every element of result bits [127:0] equals element k of source bits [127:0], and every element of result bits [255:128] equals element k of source bits [255:128]. Element k of a half with width w occupies bits [k*w +: w] of that half.
- R3: In immediate mode (`in_mode`=1), the index is the low 4, 3, 2 or 1 bits of `in_imm` for size codes 0, 1, 2 and 3. Higher immediate bits are ignored. Each half is filled from its own element as in R2.
- R4: In whole-vector mode (`in_mode`=2) with size codes 0 to 3, every element of the 256-bit result equals the lowest element of the source, bits [w-1:0].
- R5: In whole-vector mode with size code 4 (128 bits), both halves of the result equal source bits [127:0].
- R6: Illegal combinations raise `out_illegal` together with the result and force `out_vec` to zero. These are: `in_mode`=3, size code 4 in modes 0 or 1, and size codes 5 to 7 in any mode. Legal results have `out_illegal` low.
- R7: A result appears with `out_valid` high on the cycle after its operation is accepted. With `out_ready` high and no new operation, `out_valid` drops one cycle later.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_vec` and `out_illegal` hold their values. A pending input is accepted on the same edge where the waiting result is taken.
- R9: After reset, `out_valid`, `out_illegal` and `out_vec` are zero, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Unit can take an operation |
| in_mode | input | 2 | 0 scalar index, 1 immediate index, 2 whole-vector element 0, 3 illegal |
| in_size | input | 3 | Element size code: 0=8, 1=16, 2=32, 3=64, 4=128 bits |
| in_vec | input | 256 | Source vector |
| in_scalar | input | 64 | Scalar index operand |
| in_imm | input | 4 | Immediate index operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_vec | output | 256 | Broadcast result |
| out_illegal | output | 1 | Operation combination was illegal |

## Verification
The only state is the output register and its valid bit, so a fault in the index reduction or in half steering shows up on `out_vec` in the cycle right after acceptance. Wrapping scalars, oversized immediates and distinct byte patterns in each half expose wrong element selection or crossed halves. A valid bit that is wrongly cleared or kept shows up within one cycle, either as a lost result or as `out_vec` changing during a stall.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
  typedef enum logic [1:0] {
    VB_MODE_GPR  = 2'd0,
    VB_MODE_IMM  = 2'd1,
    VB_MODE_LOW  = 2'd2,
    VB_MODE_RSVD = 2'd3
  } vb_mode_e;

  localparam int unsigned VB_SZ_W = 3;
  localparam logic [VB_SZ_W-1:0] VB_SZ_8   = 3'd0;
  localparam logic [VB_SZ_W-1:0] VB_SZ_16  = 3'd1;
  localparam logic [VB_SZ_W-1:0] VB_SZ_32  = 3'd2;
  localparam logic [VB_SZ_W-1:0] VB_SZ_64  = 3'd3;
  localparam logic [VB_SZ_W-1:0] VB_SZ_128 = 3'd4;
endpackage

// File: rtl/vbc_decode.sv
module vbc_decode
  import vbc_pkg::*;
#(
  parameter int unsigned SCL_W = 64,
  parameter int unsigned IMM_W = 4,
  parameter int unsigned IDX_B = 4
) (
  input  logic [1:0]         mode_i,
  input  logic [VB_SZ_W-1:0] size_i,
  input  logic [SCL_W-1:0]   scalar_i,
  input  logic [IMM_W-1:0]   imm_i,
  output logic               legal_o,
  output logic               use_low_o,
  output logic [IDX_B-1:0]   idx_o
);
  logic unused_scalar_hi;
  assign unused_scalar_hi = ^scalar_i[SCL_W-1:IDX_B];

  always_comb begin
    legal_o   = 1'b0;
    use_low_o = 1'b0;
    idx_o     = '0;
    unique case (vb_mode_e'(mode_i))
      VB_MODE_GPR: begin
        legal_o = (size_i <= VB_SZ_64);
        idx_o   = scalar_i[IDX_B-1:0];
      end
      VB_MODE_IMM: begin
        legal_o = (size_i <= VB_SZ_64);
        idx_o   = IDX_B'(imm_i);
      end
      VB_MODE_LOW: begin
        legal_o   = (size_i <= VB_SZ_128);
        use_low_o = 1'b1;
      end
      default: legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/vbc_half_rep.sv
module vbc_half_rep
  import vbc_pkg::*;
#(
  parameter int unsigned HALF_W = 128,
  parameter int unsigned MIN_EW = 8,
  parameter int unsigned IDX_B  = 4
) (
  input  logic [HALF_W-1:0]  half_i,
  input  logic [IDX_B-1:0]   idx_i,
  input  logic [VB_SZ_W-1:0] size_i,
  output logic [HALF_W-1:0]  rep_o
);
  localparam int unsigned NSIZE = $clog2(HALF_W / MIN_EW) + 1;

  logic [HALF_W-1:0] cand [NSIZE];

  for (genvar s = 0; s < NSIZE; s++) begin : g_sz
    localparam int unsigned EW = MIN_EW << s;
    localparam int unsigned NE = HALF_W / EW;
    logic [EW-1:0] elem;
    if (NE > 1) begin : g_multi
      localparam int unsigned IB = $clog2(NE);
      logic [IB-1:0] k;
      assign k    = idx_i[IB-1:0];
      assign elem = half_i[k*EW +: EW];
    end else begin : g_whole
      assign elem = half_i;
    end
    assign cand[s] = {NE{elem}};
  end

  always_comb begin
    rep_o = '0;
    for (int s = 0; s < NSIZE; s++) begin
      if (size_i == VB_SZ_W'(s)) rep_o = cand[s];
    end
  end
endmodule

// File: rtl/vbc_out_stage.sv
module vbc_out_stage #(
  parameter int unsigned W = 257
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_valid && up_ready) begin
      dn_valid <= 1'b1;
      dn_data  <= up_data;
    end else if (dn_ready) begin
      dn_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vec_bcast_unit.sv
module vec_bcast_unit
  import vbc_pkg::*;
#(
  parameter int unsigned VEC_W  = 256,
  parameter int unsigned HALF_W = 128,
  parameter int unsigned MIN_EW = 8,
  parameter int unsigned SCL_W  = 64,
  parameter int unsigned IMM_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [1:0]         in_mode,
  input  logic [2:0]         in_size,
  input  logic [VEC_W-1:0]   in_vec,
  input  logic [SCL_W-1:0]   in_scalar,
  input  logic [IMM_W-1:0]   in_imm,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [VEC_W-1:0]   out_vec,
  output logic               out_illegal
);
  localparam int unsigned NHALF = VEC_W / HALF_W;
  localparam int unsigned IDX_B = $clog2(HALF_W / MIN_EW);

  logic             legal;
  logic             use_low;
  logic [IDX_B-1:0] idx;
  logic [VEC_W-1:0] rep;
  logic [VEC_W:0]   stage_in;
  logic [VEC_W:0]   stage_out;

  vbc_decode #(.SCL_W(SCL_W), .IMM_W(IMM_W), .IDX_B(IDX_B)) u_dec (
    .mode_i   (in_mode),
    .size_i   (in_size),
    .scalar_i (in_scalar),
    .imm_i    (in_imm),
    .legal_o  (legal),
    .use_low_o(use_low),
    .idx_o    (idx)
  );

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic [HALF_W-1:0] src;
    assign src = use_low ? in_vec[HALF_W-1:0] : in_vec[h*HALF_W +: HALF_W];
    vbc_half_rep #(.HALF_W(HALF_W), .MIN_EW(MIN_EW), .IDX_B(IDX_B)) u_rep (
      .half_i(src),
      .idx_i (use_low ? '0 : idx),
      .size_i(in_size),
      .rep_o (rep[h*HALF_W +: HALF_W])
    );
  end

  assign stage_in = legal ? {1'b0, rep} : {1'b1, {VEC_W{1'b0}}};

  vbc_out_stage #(.W(VEC_W + 1)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_valid(in_valid),
    .up_ready(in_ready),
    .up_data (stage_in),
    .dn_valid(out_valid),
    .dn_ready(out_ready),
    .dn_data (stage_out)
  );

  assign out_vec     = stage_out[VEC_W-1:0];
  assign out_illegal = stage_out[VEC_W];
endmodule

// File: rtl/vbc_checker.sv
module vbc_checker #(
  parameter int unsigned VEC_W  = 256,
  parameter int unsigned HALF_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_mode,
  input logic [2:0]       in_size,
  input logic [VEC_W-1:0] in_vec,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_vec,
  input logic             out_illegal
);
  logic take;
  assign take = in_valid && in_ready;

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vec) && $stable(out_illegal)));

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_vec == '0));

  p_rsvd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_mode == 2'd3) |=> out_illegal);

  p_quad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_mode == 2'd2 && in_size == 3'd4)
      |=> (out_vec[HALF_W +: HALF_W] == out_vec[0 +: HALF_W]) && !out_illegal);

  p_low_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_mode == 2'd2 && in_size == 3'd0)
      |=> (out_vec[7:0] == $past(in_vec[7:0])) && (out_vec[VEC_W-1 -: 8] == $past(in_vec[7:0])));
endmodule

bind vec_bcast_unit vbc_checker #(.VEC_W(VEC_W), .HALF_W(HALF_W)) u_vbc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_mode    (in_mode),
  .in_size    (in_size),
  .in_vec     (in_vec),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_vec    (out_vec),
  .out_illegal(out_illegal)
);

// File: tb/vec_bcast_unit_bench.sv
module vec_bcast_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_mode = '0;
  logic [2:0]   in_size = '0;
  logic [255:0] in_vec = '0;
  logic [63:0]  in_scalar = '0;
  logic [3:0]   in_imm = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [255:0] out_vec;
  logic         out_illegal;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vec_bcast_unit u_vec_bcast_unit (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_size(in_size), .in_vec(in_vec),
    .in_scalar(in_scalar), .in_imm(in_imm),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_vec(out_vec), .out_illegal(out_illegal)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [256:0] act, input logic [256:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] pat(input int seed);
    logic [255:0] v;
    for (int i = 0; i < 32; i++) v[i*8 +: 8] = 8'(i * 17 + seed * 29 + 5);
    return v;
  endfunction

  // Bit-level expectation: {illegal, vector}
  function automatic logic [256:0] model(input logic [1:0] m, input logic [2:0] s,
      input logic [255:0] d, input logic [63:0] sc, input logic [3:0] im);
    logic [255:0] r;
    int ew, n, k;
    if (m == 2'd3 || s > 3'd4 || (s == 3'd4 && m != 2'd2)) return {1'b1, 256'b0};
    ew = 8 << s;
    if (m == 2'd2) begin
      for (int b = 0; b < 256; b++) r[b] = d[b % ew];
    end else begin
      n = 128 / ew;
      k = (m == 2'd0) ? int'(sc % 64'(n)) : (int'(im) % n);
      for (int h = 0; h < 2; h++)
        for (int b = 0; b < 128; b++) r[h*128 + b] = d[h*128 + k*ew + (b % ew)];
    end
    return {1'b0, r};
  endfunction

  task automatic run_op(input string req, input logic [1:0] m, input logic [2:0] s,
      input logic [255:0] d, input logic [63:0] sc, input logic [3:0] im);
    logic [256:0] exp;
    exp = model(m, s, d, sc, im);
    @(negedge clk);
    in_mode = m; in_size = s; in_vec = d; in_scalar = sc; in_imm = im; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, req, "out_valid", {256'b0, out_valid}, 257'd1);
    chk({out_illegal, out_vec} == exp, req, "result", {out_illegal, out_vec}, exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0 && out_illegal == 1'b0 && out_vec == '0 && in_ready == 1'b1,
        "R9", "reset state", {out_illegal, out_vec}, 257'd0);
  endtask

  task automatic t_scalar_idx();
    // R1 wrap, R2 per-half selection
    run_op("R1", 2'd0, 3'd0, pat(1), 64'd5, 4'd0);
    run_op("R1", 2'd0, 3'd0, pat(2), 64'd17, 4'd0);
    run_op("R1", 2'd0, 3'd1, pat(3), 64'hFFFF_FFFF_FFFF_FFF3, 4'd0);
    run_op("R2", 2'd0, 3'd2, pat(4), 64'd6, 4'd0);
    run_op("R2", 2'd0, 3'd3, pat(5), 64'h8000_0000_0000_0001, 4'd0);
    run_op("R2", 2'd0, 3'd3, pat(6), 64'd2, 4'd0);
  endtask

  task automatic t_imm_idx();
    for (int s = 0; s < 4; s++) begin
      run_op("R3", 2'd1, 3'(s), pat(10 + s), 64'd9, 4'd15);
      run_op("R3", 2'd1, 3'(s), pat(20 + s), 64'd0, 4'(s * 3 + 2));
    end
  endtask

  task automatic t_low_bcast();
    for (int s = 0; s < 4; s++) run_op("R4", 2'd2, 3'(s), pat(30 + s), 64'd7, 4'd7);
    run_op("R5", 2'd2, 3'd4, pat(40), 64'd3, 4'd1);
  endtask

  task automatic t_illegal();
    run_op("R6", 2'd3, 3'd0, pat(50), 64'd1, 4'd1);
    run_op("R6", 2'd0, 3'd4, pat(51), 64'd1, 4'd1);
    run_op("R6", 2'd1, 3'd4, pat(52), 64'd1, 4'd1);
    run_op("R6", 2'd2, 3'd7, pat(53), 64'd1, 4'd1);
    run_op("R6", 2'd1, 3'd5, pat(54), 64'd1, 4'd1);
    run_op("R6", 2'd0, 3'd2, pat(55), 64'd3, 4'd0);
  endtask

  task automatic t_latency();
    run_op("R7", 2'd0, 3'd0, pat(60), 64'd4, 4'd0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7", "valid drops", {256'b0, out_valid}, 257'd0);
  endtask

  task automatic t_backpressure();
    logic [256:0] ea, eb;
    ea = model(2'd0, 3'd0, pat(70), 64'd3, 4'd0);
    eb = model(2'd1, 3'd1, pat(71), 64'd0, 4'd6);
    @(negedge clk);
    out_ready = 1'b0;
    in_mode = 2'd0; in_size = 3'd0; in_vec = pat(70); in_scalar = 64'd3; in_imm = 4'd0;
    in_valid = 1'b1;
    @(negedge clk);
    in_mode = 2'd1; in_size = 3'd1; in_vec = pat(71); in_scalar = 64'd0; in_imm = 4'd6;
    for (int c = 0; c < 3; c++) begin
      chk(in_ready == 1'b0, "R8", "in_ready low", {256'b0, in_ready}, 257'd0);
      chk(out_valid && {out_illegal, out_vec} == ea, "R8", "held result",
          {out_illegal, out_vec}, ea);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && {out_illegal, out_vec} == eb, "R8", "next accepted", {out_illegal, out_vec}, eb);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_scalar_idx();
    t_imm_idx();
    t_low_bcast();
    t_illegal();
    t_latency();
    t_backpressure();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule